// File: doc/BRIEF.md
# SM3 Round Step TT1 Datapath

This block carries out one round step of the SM3 compression function on a four-word state vector. Each input set has three 128-bit vectors and a 2-bit lane index. The first vector is the working state. The second is a message-derived word vector. The third is an expanded-message vector. Each vector is seen as four 32-bit lanes, with lane 0 in bits 31:0 and lane 3 in bits 127:96.

The index picks one lane of the expanded-message vector. That lane is added to three terms:

- the bitwise majority of the upper three state lanes,
- the lowest state lane,
- a mixed word formed from the upper lanes of the state and message vectors.

The 32-bit sum becomes the new top lane. The other output lanes are the state lanes shifted down by one position, and one of them is rotated by 9.

The result is registered. A flag marks it for one cycle after each accepted input. The block never applies backpressure, so a sequencer can issue one step per cycle.

Top module: `sm3_tt1_step`

## Requirements
- R1: All 128-bit vectors are split into four 32-bit lanes, with lane k at bits 32k+31:32k, so lane 0 is bits 31:0 and lane 3 is bits 127:96.
- R2: The index idx_i (0 to 3) selects lane idx_i of wexp_i as the added word W'.
- R3: The mixed word SS2 equals msg_i lane 3 XOR (state_i lane 3 rotated left by 12).
- R4: The boolean term is the bitwise majority of state lanes 3, 2 and 1. Each result bit is 1 when at least two of the three input bits are 1.
- R5: Result lane 3 equals majority + state lane 0 + SS2 + W', reduced modulo 2^32.
- R6: Result lane 0 equals state lane 1 unchanged.
- R7: Result lane 1 equals state lane 2 rotated left by 9.
- R8: Result lane 2 equals state lane 3 unchanged.
- R9: Each input accepted on a rising clock edge (in_valid_i high while in_ready_o is high) raises out_valid_o for exactly the next cycle, with result_o holding its result. In a cycle after an edge with no accepted input, out_valid_o is low.
- R10: in_ready_o is high whenever reset is not asserted.
- R11: Asserting rst_ni low clears out_valid_o and result_o to zero at once.
- R12: result_o keeps its previous value across any edge where no input is accepted, whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input set is valid |
| in_ready_o | output | 1 | Block can accept an input (always high out of reset) |
| state_i | input | 128 | Working state vector |
| msg_i | input | 128 | Message-derived vector (lane 3 used) |
| wexp_i | input | 128 | Expanded-message vector |
| idx_i | input | 2 | Lane select into wexp_i |
| out_valid_o | output | 1 | Result valid, one cycle per accepted input |
| result_o | output | 128 | Registered updated state vector |

## Verification
The assertions assume that the data inputs are stable and known whenever in_valid_i is high at a clock edge. They also assume that reset is released away from a clock edge. The bench meets both by driving every input on the falling edge only.

The bench sweeps all four index values with random vectors, applying them back to back and with idle gaps. It also adds directed all-ones vectors that make the four-term sum wrap past 2^32. Idle cycles put random data on the inputs, which shows that only accepted inputs reach the result.

// File: rtl/sm3_tt1_pkg.sv
package sm3_tt1_pkg;
  parameter int unsigned LANE_W  = 32;
  parameter int unsigned LANES   = 4;
  parameter int unsigned VEC_W   = LANE_W * LANES;
  parameter int unsigned IDX_W   = $clog2(LANES);
  parameter int unsigned ROT_SS2 = 12;
  parameter int unsigned ROT_MID = 9;

  typedef logic [LANE_W-1:0] lane_t;

  function automatic lane_t rol(input lane_t x, input int unsigned n);
    return (n == 0) ? x : ((x << n) | (x >> (LANE_W - n)));
  endfunction
endpackage

// File: rtl/sm3_lane_sel.sv
module sm3_lane_sel #(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned LANES  = 4,
  localparam int unsigned IDX_W = $clog2(LANES)
) (
  input  logic [LANE_W*LANES-1:0] vec_i,
  input  logic [IDX_W-1:0]        idx_i,
  output logic [LANE_W-1:0]       lane_o
);
  logic [LANE_W-1:0] lanes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign lanes[g] = vec_i[g*LANE_W +: LANE_W];
  end

  assign lane_o = lanes[idx_i];
endmodule

// File: rtl/sm3_tt1_core.sv
module sm3_tt1_core
  import sm3_tt1_pkg::*;
#(
  parameter int unsigned ROT = ROT_SS2
) (
  input  lane_t st3_i,
  input  lane_t st2_i,
  input  lane_t st1_i,
  input  lane_t st0_i,
  input  lane_t msg3_i,
  input  lane_t wj_i,
  output lane_t tt1_o
);
  lane_t maj, ss2;

  assign maj   = (st3_i & st2_i) | (st3_i & st1_i) | (st2_i & st1_i);
  assign ss2   = msg3_i ^ rol(st3_i, ROT);
  // modulo 2^LANE_W: carries drop by width
  assign tt1_o = maj + st0_i + ss2 + wj_i;
endmodule

// File: rtl/sm3_lane_perm.sv
module sm3_lane_perm
  import sm3_tt1_pkg::*;
#(
  parameter int unsigned ROT = ROT_MID
) (
  input  logic [4*LANE_W-1:0] st_i,
  input  lane_t               tt1_i,
  output logic [4*LANE_W-1:0] res_o
);
  assign res_o[0*LANE_W +: LANE_W] = st_i[1*LANE_W +: LANE_W];
  assign res_o[1*LANE_W +: LANE_W] = rol(st_i[2*LANE_W +: LANE_W], ROT);
  assign res_o[2*LANE_W +: LANE_W] = st_i[3*LANE_W +: LANE_W];
  assign res_o[3*LANE_W +: LANE_W] = tt1_i;
endmodule

// File: rtl/sm3_tt1_step.sv
module sm3_tt1_step
  import sm3_tt1_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [VEC_W-1:0] state_i,
  input  logic [VEC_W-1:0] msg_i,
  input  logic [VEC_W-1:0] wexp_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             out_valid_o,
  output logic [VEC_W-1:0] result_o
);
  lane_t             wj, tt1;
  logic [VEC_W-1:0]  res_d;
  logic              accept;

  assign in_ready_o = rst_ni;
  assign accept     = in_valid_i & in_ready_o;

  sm3_lane_sel #(.LANE_W(LANE_W), .LANES(LANES)) u_sel (
    .vec_i (wexp_i),
    .idx_i (idx_i),
    .lane_o(wj)
  );

  sm3_tt1_core #(.ROT(ROT_SS2)) u_core (
    .st3_i (state_i[3*LANE_W +: LANE_W]),
    .st2_i (state_i[2*LANE_W +: LANE_W]),
    .st1_i (state_i[1*LANE_W +: LANE_W]),
    .st0_i (state_i[0*LANE_W +: LANE_W]),
    .msg3_i(msg_i[3*LANE_W +: LANE_W]),
    .wj_i  (wj),
    .tt1_o (tt1)
  );

  sm3_lane_perm #(.ROT(ROT_MID)) u_perm (
    .st_i (state_i),
    .tt1_i(tt1),
    .res_o(res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
    end else begin
      out_valid_o <= accept;
      if (accept) result_o <= res_d;
    end
  end

  // R9
  valid_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o);
  // R9
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> !out_valid_o);
  // R12
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> $stable(result_o));
  // R6
  lane0_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> result_o[LANE_W-1:0] == $past(state_i[2*LANE_W-1:LANE_W]));
  // R8
  lane2_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> result_o[3*LANE_W-1:2*LANE_W] == $past(state_i[4*LANE_W-1:3*LANE_W]));
  // R7
  lane1_rot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> result_o[2*LANE_W-1:LANE_W] == rol($past(state_i[3*LANE_W-1:2*LANE_W]), ROT_MID));
endmodule

// File: tb/sm3_tt1_step_tb_top.sv
`timescale 1ns/1ps
module sm3_tt1_step_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni, in_valid_i, in_ready_o, out_valid_o;
  logic [127:0] state_i, msg_i, wexp_i, result_o;
  logic [1:0]   idx_i;
  int n_chk = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  sm3_tt1_step dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .state_i(state_i), .msg_i(msg_i), .wexp_i(wexp_i), .idx_i(idx_i),
    .out_valid_o(out_valid_o), .result_o(result_o)
  );

  function automatic logic [31:0] r32(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [127:0] model(input logic [127:0] s, m, w, input logic [1:0] ix);
    logic [31:0] maj, ss2, wj;
    logic [33:0] sum;
    wj  = w[ix*32 +: 32];
    ss2 = m[127:96] ^ r32(s[127:96], 12);
    for (int b = 0; b < 32; b++)
      maj[b] = (32'(s[127-31+b]) + 32'(s[95-31+b]) + 32'(s[63-31+b])) >= 2;
    sum = 34'(maj) + 34'(s[31:0]) + 34'(ss2) + 34'(wj);
    return {sum[31:0], s[127:96], r32(s[95:64], 9), s[63:32]};
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input logic [127:0] s, m, w, input logic [1:0] ix);
    logic [127:0] e;
    e = model(s, m, w, ix);
    state_i = s; msg_i = m; wexp_i = w; idx_i = ix; in_valid_i = 1'b1;
    @(negedge clk_i);
    chk("R9 R10 valid/ready", {126'd0, out_valid_o, in_ready_o}, 128'd3);
    chk("R1 R6 lane0", {96'd0, result_o[31:0]},   {96'd0, e[31:0]});
    chk("R1 R7 lane1", {96'd0, result_o[63:32]},  {96'd0, e[63:32]});
    chk("R8 lane2",    {96'd0, result_o[95:64]},  {96'd0, e[95:64]});
    chk("R2 R3 R4 R5 lane3", {96'd0, result_o[127:96]}, {96'd0, e[127:96]});
  endtask

  task automatic idle_cyc();
    logic [127:0] prev;
    prev = result_o;
    in_valid_i = 1'b0;
    state_i = {4{$urandom}}; msg_i = {4{$urandom}}; wexp_i = {4{$urandom}}; idx_i = 2'($urandom);
    @(negedge clk_i);
    chk("R9 no valid when idle", {127'd0, out_valid_o}, 128'd0);
    chk("R12 hold when idle", result_o, prev);
  endtask

  function automatic logic [127:0] rv();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; in_valid_i = 1'b0;
    state_i = '0; msg_i = '0; wexp_i = '0; idx_i = '0;
    repeat (3) @(negedge clk_i);
    chk("R11 reset valid", {127'd0, out_valid_o}, 128'd0);
    chk("R11 reset result", result_o, 128'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 ready out of reset", {127'd0, in_ready_o}, 128'd1);

    // R2: distinct expanded lanes, everything else zero
    for (int ix = 0; ix < 4; ix++)
      run_vec('0, '0, {32'hd0d0_0003, 32'hc0c0_0002, 32'hb0b0_0001, 32'ha0a0_0000}, 2'(ix));
    // R3: only message lane 3 and state lane 3 feed SS2
    run_vec({32'h0000_0001, 96'd0}, {32'h1234_5678, 96'd0}, '0, 2'd0);
    // R4: majority patterns
    run_vec({32'hff00_ff00, 32'hf0f0_f0f0, 32'hcccc_cccc, 32'd0}, '0, '0, 2'd1);
    // R5: all-ones wrap
    for (int ix = 0; ix < 4; ix++)
      run_vec({128{1'b1}}, {128{1'b1}}, {128{1'b1}}, 2'(ix));
    idle_cyc();

    for (int ix = 0; ix < 4; ix++)
      for (int k = 0; k < 150; k++) begin
        run_vec(rv(), rv(), rv(), 2'(ix));
        if (k % 5 == 4) idle_cyc();
      end

    // R11: asynchronous reset mid-run
    run_vec(rv(), rv(), rv(), 2'd2);
    in_valid_i = 1'b0;
    #3 rst_ni = 1'b0;
    #2;
    chk("R11 async clear valid", {127'd0, out_valid_o}, 128'd0);
    chk("R11 async clear result", result_o, 128'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_vec({128{1'b1}}, rv(), {128{1'b1}}, 2'd3);
    idle_cyc();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule